// File: doc/BRIEF.md
# Shared PCI Bus Central Arbiter with Idle Parking

This block decides which of six bus masters may drive a shared PCI-style bus. Master 0 is the on-chip host bridge; masters 1 to 5 are external devices. Each master has one active-low request line and one active-low grant line. The arbiter watches the bus through FRAME# and IRDY#. It picks the next owner while the current transfer is still running, so the choice is ready when that transfer finishes. When the bus goes idle and nobody is asking for it, the grant rests on a selectable parking master, so that some master keeps driving the bus lines.

Requesters are served in round-robin order. A master that has the bus keeps it for as long as its transaction runs: there is no timer that takes the bus back mid-transfer. The only forced removal is for a master that holds a grant on an idle bus and never starts a cycle. Grants move only at points where handing over is safe. Whenever the grant passes from one master to a different one, there is one cycle in which no grant is asserted.

Top module: `pci_park_arbiter`

## Requirements
- R1: At most one bit of `gnt_n` is low in any cycle. While `rst_n` is low, and in the first cycle after reset, all grants are high.
- R2: Bit i of `req_n` and bit i of `gnt_n` belong to master i, and bit 0 is the host bridge. A grant goes to a master only if that master is requesting, or if it is the parking master.
- R3: When several masters request at once, the winner is the first requester found by counting upward (with wraparound) from the master that last won a grant by requesting. After reset, this search starts at master 0.
- R4: The bus is idle when `frame_n` and `irdy_n` are both high. The grant may change only in an idle cycle, or in the cycle where `frame_n` is high while it was low in the cycle before. The grant never changes in the cycle after one in which `frame_n` was low, so a running transfer is never cut short.
- R5: When the grant moves from one master to a different master, `gnt_n` is all ones for exactly one cycle in between.
- R6: If the bus is idle and no master requests, the grant is parked on the master whose index is on `park_sel`. A value of 6 or 7 parks on master 0.
- R7: If the parking master itself starts requesting, it keeps its grant with no gap cycle and becomes the requesting owner.
- R8: If a master was granted because it requested, and the bus then stays idle for 16 consecutive granted cycles, the grant is removed after the 16th cycle and arbitration runs again.
- R9: Arbitration is registered. A request seen in a cycle with no grant active is granted on the next clock edge. A handover decided on the frame-end cycle shows as the gap on the next edge and as the new grant on the edge after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 6 | Active-low requests, bit i from master i (bit 0 host bridge) |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| park_sel | input | 3 | Index of the parking master; values 6 and 7 select master 0 |
| gnt_n | output | 6 | Active-low grants, bit i to master i |

## Verification
The bench targets the handover points. In a last-data-phase cycle, where FRAME# is high but IRDY# is still low, an arbiter that waited for full idle would lose a cycle, and one that switched on any FRAME# high would take the bus from a master still in wait states. The bench checks the round-robin pointer after a master wins by requesting: a design that did not rotate would keep serving the same low index. It also checks that a parked master which starts to request keeps its grant with no spurious gap cycle. Finally, it checks the idle-grant timeout at exactly the 16th cycle, one cycle early or late being the likely error, and it checks that an out-of-range park selection falls back to the host bridge.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

    // Default sizing of the arbiter
    localparam int ARB_MASTERS    = 6;
    localparam int ARB_IDLE_LIMIT = 16;

    // Master index of the internal host bridge; also the fallback parking master
    localparam int ARB_HOST_IDX   = 0;

endpackage

// File: rtl/pci_arb_rr_pick.sv
// Round-robin selector: the first requester found counting upward (with wrap)
// from the index that follows the last winner.
module pci_arb_rr_pick #(
    parameter int N_MASTERS = 6,
    localparam int IDX_W    = $clog2(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [IDX_W-1:0]     last,
    output logic                 any,
    output logic [IDX_W-1:0]     win
);

    always_comb begin
        any = 1'b0;
        win = '0;
        for (int k = 1; k <= N_MASTERS; k++) begin
            int idx;
            idx = (int'(last) + k) % N_MASTERS;
            if (!any && req[idx]) begin
                any = 1'b1;
                win = IDX_W'(idx);
            end
        end
    end

endmodule

// File: rtl/pci_arb_idle_timer.sv
// Counts consecutive enabled cycles and flags the LIMIT-th one.
module pci_arb_idle_timer #(
    parameter int LIMIT = 16,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic expire
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = count_en ? cnt_q + 1'b1 : '0;
        expire = count_en && (cnt_q == CW'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pci_park_arbiter.sv
module pci_park_arbiter
    import pci_arb_pkg::*;
#(
    parameter int N_MASTERS  = ARB_MASTERS,
    parameter int IDLE_LIMIT = ARB_IDLE_LIMIT,
    localparam int IDX_W     = $clog2(N_MASTERS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_n,
    input  logic                 frame_n,
    input  logic                 irdy_n,
    input  logic [IDX_W-1:0]     park_sel,
    output logic [N_MASTERS-1:0] gnt_n
);

    typedef struct packed {
        logic             gnt_vld;    // a grant is being driven
        logic [IDX_W-1:0] owner;      // index of the granted master
        logic             parked;     // grant is a parking grant
        logic [IDX_W-1:0] last;       // last master granted on request
        logic             frame_prev; // frame_n of the previous cycle
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic [N_MASTERS-1:0] req;
    logic                 bus_idle;
    logic                 switch_ok;
    logic                 pick_any;
    logic [IDX_W-1:0]     pick_win;
    logic [IDX_W-1:0]     park_idx;
    logic                 idle_cnt_en;
    logic                 idle_expire;

    assign req       = ~req_n;
    assign bus_idle  = frame_n & irdy_n;
    // Safe handover: idle bus, or the first cycle with FRAME# released
    assign switch_ok = frame_n & (irdy_n | ~state_q.frame_prev);
    assign park_idx  = (int'(park_sel) < N_MASTERS) ? park_sel : IDX_W'(ARB_HOST_IDX);

    pci_arb_rr_pick #(
        .N_MASTERS (N_MASTERS)
    ) u_pick (
        .req  (req),
        .last (state_q.last),
        .any  (pick_any),
        .win  (pick_win)
    );

    assign idle_cnt_en = state_q.gnt_vld & ~state_q.parked & bus_idle;

    pci_arb_idle_timer #(
        .LIMIT (IDLE_LIMIT)
    ) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (idle_cnt_en),
        .expire   (idle_expire)
    );

    always_comb begin
        state_d            = state_q;
        state_d.frame_prev = frame_n;

        if (!state_q.gnt_vld) begin
            // Gap or post-reset cycle: hand out a fresh grant
            state_d.gnt_vld = 1'b1;
            if (pick_any) begin
                state_d.owner  = pick_win;
                state_d.parked = 1'b0;
                state_d.last   = pick_win;
            end else begin
                state_d.owner  = park_idx;
                state_d.parked = 1'b1;
            end
        end else if (idle_expire) begin
            // Granted master never started a cycle: take the grant back
            state_d.gnt_vld = 1'b0;
        end else if (switch_ok) begin
            if (pick_any) begin
                if (pick_win == state_q.owner) begin
                    // Owner is the only requester (or a parked master asking)
                    state_d.parked = 1'b0;
                    state_d.last   = state_q.owner;
                end else begin
                    state_d.gnt_vld = 1'b0;
                end
            end else if (state_q.owner == park_idx) begin
                state_d.parked = 1'b1;
            end else begin
                state_d.gnt_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.gnt_vld    <= 1'b0;
            state_q.owner      <= IDX_W'(ARB_HOST_IDX);
            state_q.parked     <= 1'b0;
            state_q.last       <= IDX_W'(N_MASTERS - 1);
            state_q.frame_prev <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        gnt_n = '1;
        if (state_q.gnt_vld) gnt_n[state_q.owner] = 1'b0;
    end

endmodule

// File: rtl/pci_arb_checker.sv
module pci_arb_checker #(
    parameter int N_MASTERS = 6,
    localparam int IDX_W    = $clog2(N_MASTERS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_MASTERS-1:0] req_n,
    input logic                 frame_n,
    input logic                 irdy_n,
    input logic [IDX_W-1:0]     park_sel,
    input logic [N_MASTERS-1:0] gnt_n
);

    logic                 idle_no_req;
    logic [N_MASTERS-1:0] park_onehot;

    always_comb begin
        idle_no_req = frame_n & irdy_n & (&req_n);
        park_onehot = '0;
        if (int'(park_sel) < N_MASTERS) park_onehot[park_sel] = 1'b1;
        else                            park_onehot[0]        = 1'b1;
    end

    // R1: never two grants at once
    p_one_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~gnt_n));

    // R5: two consecutive granted cycles always belong to the same master
    p_gap_between_owners_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~gnt_n != '0) && ($past(~gnt_n) != '0)) |-> (gnt_n == $past(gnt_n)));

    // R4: no grant change right after a cycle with FRAME# asserted
    p_hold_during_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> $stable(gnt_n));

    // R6: two idle, request-free cycles with a steady selection park the bus there
    p_park_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_no_req && $past(idle_no_req) && $stable(park_sel))
        |=> (gnt_n == ~$past(park_onehot)));

endmodule

bind pci_park_arbiter pci_arb_checker #(
    .N_MASTERS (N_MASTERS)
) u_arb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n    (req_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .park_sel (park_sel),
    .gnt_n    (gnt_n)
);

// File: tb/pci_park_arbiter_bench.sv
module pci_park_arbiter_bench;

    localparam int NM  = 6;
    localparam int NV  = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] req_n = '1;
    logic          frame_n = 1'b1;
    logic          irdy_n = 1'b1;
    logic [2:0]    park_sel = 3'd0;
    logic [NM-1:0] gnt_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    pci_park_arbiter u_pci_park_arbiter (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_n    (req_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .park_sel (park_sel),
        .gnt_n    (gnt_n)
    );

    // {req_n, frame_n, irdy_n, park_sel, expected gnt_n after the edge}
    localparam logic [16:0] VEC [NV] = '{
        {6'h3F, 1'b1, 1'b1, 3'd0, 6'h3E},  //  0 R6 park on host
        {6'h3F, 1'b1, 1'b1, 3'd0, 6'h3E},  //  1 R6 stays parked
        {6'h37, 1'b1, 1'b1, 3'd0, 6'h3F},  //  2 R5 gap before master 3
        {6'h37, 1'b1, 1'b1, 3'd0, 6'h37},  //  3 R2 master 3 granted
        {6'h37, 1'b0, 1'b1, 3'd0, 6'h37},  //  4 R4 address phase
        {6'h35, 1'b0, 1'b0, 3'd0, 6'h37},  //  5 R4 no preemption
        {6'h35, 1'b0, 1'b0, 3'd0, 6'h37},  //  6 R4 no preemption
        {6'h35, 1'b1, 1'b0, 3'd0, 6'h3F},  //  7 R9 handover at frame end
        {6'h35, 1'b1, 1'b1, 3'd0, 6'h3D},  //  8 R3 master 1 after 3
        {6'h3D, 1'b0, 1'b1, 3'd0, 6'h3D},  //  9 R4
        {6'h35, 1'b0, 1'b0, 3'd0, 6'h3D},  // 10 R4
        {6'h35, 1'b1, 1'b0, 3'd0, 6'h3F},  // 11 R5 gap
        {6'h35, 1'b1, 1'b1, 3'd0, 6'h37},  // 12 R3 rotates to 3
        {6'h3F, 1'b1, 1'b1, 3'd0, 6'h3F},  // 13 R5 gap before parking
        {6'h3F, 1'b1, 1'b1, 3'd0, 6'h3E},  // 14 R6 parked on host
        {6'h3F, 1'b1, 1'b1, 3'd5, 6'h3F},  // 15 R6 new park target
        {6'h3F, 1'b1, 1'b1, 3'd5, 6'h1F},  // 16 R6 parked on 5
        {6'h1F, 1'b1, 1'b1, 3'd5, 6'h1F},  // 17 R7 parked master requests
        {6'h1F, 1'b0, 1'b1, 3'd5, 6'h1F},  // 18 R4
        {6'h3F, 1'b1, 1'b0, 3'd5, 6'h1F},  // 19 R6 owner is park target
        {6'h3F, 1'b1, 1'b1, 3'd0, 6'h3F},  // 20 R5
        {6'h3F, 1'b1, 1'b1, 3'd0, 6'h3E},  // 21 R6
        {6'h2B, 1'b1, 1'b1, 3'd0, 6'h3F},  // 22 R5
        {6'h2B, 1'b1, 1'b1, 3'd0, 6'h3B},  // 23 R3 master 2 after 5
        {6'h2B, 1'b0, 1'b1, 3'd0, 6'h3B},  // 24 R4
        {6'h2B, 1'b1, 1'b0, 3'd0, 6'h3F},  // 25 R9
        {6'h2B, 1'b1, 1'b1, 3'd0, 6'h2F},  // 26 R3 master 4 after 2
        {6'h3F, 1'b1, 1'b1, 3'd0, 6'h3F},  // 27 R5
        {6'h3F, 1'b1, 1'b1, 3'd0, 6'h3E}   // 28 R6
    };

    task automatic check(input string req_tag, input logic [NM-1:0] act,
                         input logic [NM-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: gnt_n actual %h expected %h", req_tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 during reset", gnt_n, 6'h3F);
        rst_n = 1'b1;
        check("R1 first cycle after reset", gnt_n, 6'h3F);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            {req_n, frame_n, irdy_n, park_sel} = VEC[v][16:6];
            @(negedge clk);
            check($sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R9)", v), gnt_n, VEC[v][5:0]);
            checks++;
            if ($countones(~gnt_n) > 1) begin
                errors++;
                $display("FAIL R1 vector %0d: grants low %0d expected <=1", v,
                         $countones(~gnt_n));
            end
        end

        // R8 / R9: idle grant timeout
        req_n = 6'h3B; frame_n = 1'b1; irdy_n = 1'b1; park_sel = 3'd0;
        do_reset();
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            if (k == 1)       check("R9 grant from gap", gnt_n, 6'h3B);
            else if (k <= 16) check($sformatf("R8 still granted cycle %0d", k), gnt_n, 6'h3B);
            else if (k == 17) check("R8 grant removed after 16 idle", gnt_n, 6'h3F);
            else              check("R8 re-arbitrated", gnt_n, 6'h3B);
        end

        // R1: asynchronous reset while granted
        rst_n = 1'b0;
        #1;
        check("R1 reset drops grant", gnt_n, 6'h3F);

        // R6: out-of-range park selection falls back to host
        req_n = '1; park_sel = 3'd7;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 park_sel 7 parks host", gnt_n, 6'h3E);
        park_sel = 3'd6;
        @(negedge clk);
        check("R6 park_sel 6 parks host", gnt_n, 6'h3E);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule